// File: doc/BRIEF.md
# Eight-Bit Arithmetic-Logic Unit with Latched Condition Flags

This block computes an 8-bit result from two operands and a 4-bit operation code, without a clock. It covers addition, subtraction, the three bitwise logic functions, single-bit shifts in both directions, multiplication that keeps the low byte, unsigned division and compare. Each operation also produces zero, negative, carry and overflow conditions. The carry and overflow rules differ from one operation to the next.

The four condition flags sit in a small register. That register loads only on a clock edge where the flag-enable input is high, so the core around the block decides when the flags change. A separate output marks results that must not be written back to a register. Compare raises it, and so does any unassigned operation code. Register files, memory and sequencing stay outside the block.

Top module: `alu8_flags`

## Requirements
- R1: Code 0 (add) returns the low 8 bits of A+B. Carry is the carry out of bit 7. Overflow is set when result bit 7 differs from bit 7 of both A and B.
- R2: Code 1 (subtract) returns A + ~B + 1. Carry is the carry out of bit 7, so it is 1 exactly when A >= B as unsigned numbers (no borrow). Overflow is set when A and B differ in bit 7 and the result differs from A in bit 7.
- R3: Codes 2, 3 and 4 return A AND B, A OR B and A XOR B. They clear carry and overflow.
- R4: Code 5 shifts A left by one and fills bit 0 with 0, and carry takes old A bit 7. Code 6 shifts A right logically and fills bit 7 with 0, and carry takes old A bit 0. Both clear overflow.
- R5: Code 7 returns the low byte of the unsigned product A*B. Carry is set when the product exceeds 255, and overflow is cleared.
- R6: Code 8 returns the unsigned quotient A/B with carry and overflow cleared. When B is 0 it returns 0 with both carry and overflow set.
- R7: Code 9 (compare) gives the same result and flags as subtract and drives skip_wb high. Codes 0 to 8 drive skip_wb low.
- R8: For codes 0 to 9 the zero flag is set when the 8-bit result is 0, and the negative flag copies result bit 7.
- R9: The flags load only on a rising clock edge with flag_en high. On any other edge they hold.
- R10: A synchronous reset clears all four flags, and it takes priority over flag_en.
- R11: Codes 10 to 15 pass A to the result and drive skip_wb high. The flags hold even when flag_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| opa_i | input | 8 | First operand A |
| opb_i | input | 8 | Second operand B |
| flag_en_i | input | 1 | Load the flag register on this edge |
| res_o | output | 8 | Combinational result |
| skip_wb_o | output | 1 | Result must not be written back |
| zf_o | output | 1 | Registered zero flag |
| nf_o | output | 1 | Registered negative flag |
| cf_o | output | 1 | Registered carry flag |
| vf_o | output | 1 | Registered overflow flag |

## Verification
The bench compares the result of every operation code against an integer reference for all 65,536 operand pairs. This catches a divider that is off by one at exact multiples, a multiplier that drops bits, and a shift that fills from the wrong end. Directed flag tests aim at the sign boundaries 0x7F/0x80 and at equal and one-apart subtract operands. A design that set carry on borrow instead of on no-borrow would fail here, as would one that took subtract overflow from the add formula. Division by zero must give result 0 with both carry and overflow set; a plain divider would give 0xFF with no flags. Other tests update flags with flag_en low, with an unassigned code, and with reset and enable together. These catch a register that loads every cycle, lets junk codes disturb the flags, or gives enable priority over reset.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         flag_en_i,
  output logic [W-1:0] res_o,
  output logic         skip_wb_o,
  output logic         zf_o,
  output logic         nf_o,
  output logic         cf_o,
  output logic         vf_o
);

  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_OR  = 4'd3;
  localparam logic [3:0] OP_XOR = 4'd4;
  localparam logic [3:0] OP_SHL = 4'd5;
  localparam logic [3:0] OP_SHR = 4'd6;
  localparam logic [3:0] OP_MUL = 4'd7;
  localparam logic [3:0] OP_DIV = 4'd8;
  localparam logic [3:0] OP_CMP = 4'd9;

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;
  logic [2*W-1:0] prod;
  logic [W-1:0] quot;
  logic [W:0]   div_part;
  logic [W-1:0] r;
  logic         c, v, legal;

  // One adder serves add, subtract and compare.
  assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign b_eff  = is_sub ? ~opb_i : opb_i;
  assign sum    = {1'b0, opa_i} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
  assign prod   = {{W{1'b0}}, opa_i} * {{W{1'b0}}, opb_i};

  always_comb begin
    div_part = '0;
    quot     = '0;
    for (int i = MSB; i >= 0; i--) begin
      div_part = {div_part[W-1:0], opa_i[i]};
      if (div_part >= {1'b0, opb_i}) begin
        div_part = div_part - {1'b0, opb_i};
        quot[i]  = 1'b1;
      end
    end
  end

  always_comb begin
    r     = opa_i;
    c     = 1'b0;
    v     = 1'b0;
    legal = 1'b1;
    case (op_i)
      OP_ADD, OP_SUB, OP_CMP: begin
        r = sum[W-1:0];
        c = sum[W];
        v = (opa_i[MSB] ^ sum[MSB]) & (b_eff[MSB] ^ sum[MSB]);
      end
      OP_AND: r = opa_i & opb_i;
      OP_OR:  r = opa_i | opb_i;
      OP_XOR: r = opa_i ^ opb_i;
      OP_SHL: begin
        r = {opa_i[W-2:0], 1'b0};
        c = opa_i[MSB];
      end
      OP_SHR: begin
        r = {1'b0, opa_i[W-1:1]};
        c = opa_i[0];
      end
      OP_MUL: begin
        r = prod[W-1:0];
        c = |prod[2*W-1:W];
      end
      OP_DIV: begin
        if (opb_i == '0) begin
          r = '0;
          c = 1'b1;
          v = 1'b1;
        end else begin
          r = quot;
        end
      end
      default: legal = 1'b0;
    endcase
  end

  assign res_o     = r;
  assign skip_wb_o = (op_i == OP_CMP) || !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      zf_o <= 1'b0;
      nf_o <= 1'b0;
      cf_o <= 1'b0;
      vf_o <= 1'b0;
    end else if (flag_en_i && legal) begin
      zf_o <= (r == '0);
      nf_o <= r[MSB];
      cf_o <= c;
      vf_o <= v;
    end
  end

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> !zf_o && !nf_o && !cf_o && !vf_o);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_en_i |=> $stable({zf_o, nf_o, cf_o, vf_o}));

  assert_bad_code_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (op_i > OP_CMP) |=> $stable({zf_o, nf_o, cf_o, vf_o}));

  assert_logic_clear_R3: assert property (@(posedge clk) disable iff (rst)
    flag_en_i && (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR) |=> !cf_o && !vf_o);

  assert_div_zero_R6: assert property (@(posedge clk) disable iff (rst)
    flag_en_i && op_i == OP_DIV && opb_i == '0 |=> cf_o && vf_o && zf_o);

  assert_sign_copy_R8: assert property (@(posedge clk) disable iff (rst)
    flag_en_i && op_i <= OP_CMP |=> nf_o == $past(res_o[MSB]));

  assert_sub_carry_R2: assert property (@(posedge clk) disable iff (rst)
    flag_en_i && is_sub |=> cf_o == $past(opa_i >= opb_i));

endmodule

// File: tb/alu8_flags_bench.sv
module alu8_flags_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       fen;
  logic [7:0] res;
  logic       skip_wb, zf, nf, cf, vf;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk(clk), .rst(rst), .op_i(op), .opa_i(a), .opb_i(b), .flag_en_i(fen),
    .res_o(res), .skip_wb_o(skip_wb), .zf_o(zf), .nf_o(nf), .cf_o(cf), .vf_o(vf)
  );

  // Returns {carry, overflow, result}
  function automatic logic [9:0] ref_calc(int o, int x, int y);
    int s, rr;
    logic cc, vv;
    rr = x; cc = 0; vv = 0;
    case (o)
      0: begin s = x + y; rr = s & 255; cc = s > 255; vv = ((x ^ rr) & (y ^ rr) & 128) != 0; end
      1, 9: begin s = x + (255 - y) + 1; rr = s & 255; cc = s > 255; vv = ((x ^ y) & (x ^ rr) & 128) != 0; end
      2: rr = x & y;
      3: rr = x | y;
      4: rr = x ^ y;
      5: begin rr = (x << 1) & 255; cc = x >= 128; end
      6: begin rr = x >> 1; cc = (x & 1) != 0; end
      7: begin s = x * y; rr = s & 255; cc = s > 255; end
      8: if (y == 0) begin rr = 0; cc = 1; vv = 1; end else rr = x / y;
      default: rr = x;
    endcase
    return {cc, vv, rr[7:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic flag_step(int o, int x, int y, string req);
    logic [9:0] e;
    @(negedge clk);
    op = o[3:0]; a = x[7:0]; b = y[7:0]; fen = 1;
    @(negedge clk);
    fen = 0;
    e = ref_calc(o, x, y);
    chk({zf, nf, cf, vf} == {e[7:0] == 0, e[7], e[9], e[8]}, req,
        {zf, nf, cf, vf}, {e[7:0] == 0, e[7], e[9], e[8]});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk({zf, nf, cf, vf} == 4'b0, "R10 reset state", {zf, nf, cf, vf}, 0);
  endtask

  task automatic t_exhaustive;
    for (int o = 0; o < 10; o++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++) begin
          logic [9:0] e;
          op = o[3:0]; a = x[7:0]; b = y[7:0];
          #1;
          e = ref_calc(o, x, y);
          chk(res == e[7:0], "R1-R6 exhaustive result", res, e[7:0]);
        end
  endtask

  task automatic t_add_sub;
    flag_step(0, 8'h7F, 8'h01, "R1 add signed overflow");
    flag_step(0, 8'hFF, 8'h01, "R1 add carry zero");
    flag_step(0, 8'h80, 8'h80, "R1 add both negative");
    flag_step(0, 8'h12, 8'h34, "R1 add plain");
    flag_step(1, 8'h05, 8'h05, "R2 sub equal no borrow");
    flag_step(1, 8'h04, 8'h05, "R2 sub borrow");
    flag_step(1, 8'h80, 8'h01, "R2 sub overflow");
    flag_step(1, 8'h7F, 8'hFF, "R2 sub overflow neg B");
  endtask

  task automatic t_logic;
    flag_step(0, 8'hFF, 8'hFF, "R3 preset carry");
    flag_step(2, 8'hF0, 8'h0F, "R3 and zero clears C");
    flag_step(1, 8'h80, 8'h01, "R3 preset V");
    flag_step(3, 8'h80, 8'h01, "R3 or clears V");
    flag_step(4, 8'hAA, 8'hAA, "R3 xor zero");
  endtask

  task automatic t_shift;
    flag_step(5, 8'h80, 0, "R4 shl carry out zero result");
    flag_step(5, 8'h41, 0, "R4 shl into sign");
    flag_step(6, 8'h01, 0, "R4 shr carry out");
    flag_step(6, 8'hFE, 0, "R4 shr fill zero");
  endtask

  task automatic t_mul_div;
    flag_step(7, 8'h10, 8'h10, "R5 mul lost high byte");
    flag_step(7, 8'h0F, 8'h11, "R5 mul exact 255");
    flag_step(8, 8'hC8, 8'h07, "R6 div quotient");
    flag_step(8, 8'h42, 8'h00, "R6 div by zero");
    chk(res == 8'h00, "R6 div by zero result", res, 0);
    flag_step(8, 8'h03, 8'h04, "R6 div zero quotient");
  endtask

  task automatic t_compare;
    flag_step(9, 8'h10, 8'h20, "R7 cmp flags");
    chk(skip_wb == 1'b1, "R7 cmp skip", skip_wb, 1);
    flag_step(9, 8'h20, 8'h20, "R8 cmp zero");
    op = 4'd0; #1;
    chk(skip_wb == 1'b0, "R7 add writes back", skip_wb, 0);
    op = 4'd8; #1;
    chk(skip_wb == 1'b0, "R7 div writes back", skip_wb, 0);
  endtask

  task automatic t_hold;
    flag_step(1, 8'h00, 8'h01, "R9 setup N C=0");
    @(negedge clk);
    op = 4'd0; a = 8'h00; b = 8'h00; fen = 0;
    @(negedge clk); @(negedge clk);
    chk({zf, nf, cf, vf} == 4'b0100, "R9 hold without enable", {zf, nf, cf, vf}, 4'b0100);
  endtask

  task automatic t_bad_code;
    for (int o = 10; o < 16; o++) begin
      @(negedge clk);
      op = o[3:0]; a = 8'h00; b = 8'h5A; fen = 1;
      #1;
      chk(res == 8'h00 && skip_wb, "R11 pass A and skip", {skip_wb, res}, 9'h100);
      @(negedge clk);
      fen = 0;
      chk({zf, nf, cf, vf} == 4'b0100, "R11 flags held", {zf, nf, cf, vf}, 4'b0100);
    end
  endtask

  task automatic t_reset_priority;
    flag_step(8, 8'h01, 8'h00, "R10 preset flags");
    @(negedge clk);
    op = 4'd0; a = 8'h80; b = 8'h80; fen = 1; rst = 1;
    @(negedge clk);
    rst = 0; fen = 0;
    chk({zf, nf, cf, vf} == 4'b0, "R10 reset beats enable", {zf, nf, cf, vf}, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    rst = 1; fen = 0; op = 0; a = 0; b = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst = 0;
    t_add_sub;
    t_logic;
    t_shift;
    t_mul_div;
    t_compare;
    t_hold;
    t_bad_code;
    t_reset_priority;
    @(negedge clk);
    t_exhaustive;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary;
      $finish;
    end
  end

endmodule